// File: doc/BRIEF.md
# Socket Interrupt Control and Status

This block is the host-side register and interrupt unit of a two-socket card controller. One control byte serves both sockets and is never copied per socket. It selects how each of three host interrupt outputs is signalled: card A functional requests, card B functional requests, and card status changes. It also selects how the status-change flags are cleared, and whether the card outputs are held in a low-power floating state.

Four card status inputs are watched. Any transition on one of them, rising or falling, sets a sticky flag. The flags stay set until software clears them. Software clears them either by reading the status register or by writing 1s back to the bits it wants cleared. Which of the two methods applies is chosen at run time by a control bit. While power-down is selected, a card-output enable stays low except during an active card access. Interrupts are still captured and signalled during power-down.

Software reaches the block through a small synchronous register bus. `bus_sel` low addresses the control register and high addresses the status register. Read data appears on `bus_rdata` one clock after the read strobe, and is zero in cycles without a read.

Top module: `sock_irq_ctl`

## Requirements
- R1: After reset the control register reads 00h, the status register reads 00h, all three interrupt outputs are low and `card_oe` is high.
- R2: Control bits 7..5 always read 0 and ignore writes. Bits 4..0 read back the value last written.
- R3: Control bit 3 sets the card A mode. When it is 0 (edge mode), each rise of `card_a_req` gives a single-clock high on `irq_a` one clock later. When it is 1 (level mode), `irq_a` follows `card_a_req` delayed by one clock.
- R4: Control bit 4 sets the card B mode for `card_b_req` and `irq_b` in the same way as R3. The two sources are independent of each other.
- R5: The status register holds sticky flags in these bit positions: bit 0 card detect change, bit 1 ready change, bit 2 battery warning change, bit 3 battery dead change. Bits 7..4 read 0. A transition of either polarity on an input sets its flag.
- R6: With control bit 2 = 0, a status read returns the flags and clears all of them.
- R7: With control bit 2 = 1, a status write clears exactly the flags whose data bits are 1, and a status read leaves the flags unchanged. With bit 2 = 0, a status write has no effect.
- R8: If a status event arrives in the same cycle that its flag is cleared, the flag stays set.
- R9: Control bit 1 sets the status-change interrupt mode. In edge mode, `irq_csc` pulses for one clock one cycle after the OR of the flags rises. In level mode, `irq_csc` is high one clock after, and for as long as, any flag is set.
- R10: With control bit 0 = 0, `card_oe` is high. With bit 0 = 1, `card_oe` equals `card_access` in the same cycle, while flags and interrupts keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 = control, 1 = status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one clock after the strobe |
| card_a_req | input | 1 | Card A functional interrupt request |
| card_b_req | input | 1 | Card B functional interrupt request |
| cd_in | input | 1 | Card detect status input |
| rdy_in | input | 1 | Ready status input |
| bwarn_in | input | 1 | Battery warning status input |
| bdead_in | input | 1 | Battery dead status input |
| card_access | input | 1 | High while a card access cycle is active |
| irq_a | output | 1 | Host interrupt for card A |
| irq_b | output | 1 | Host interrupt for card B |
| irq_csc | output | 1 | Host interrupt for status changes |
| card_oe | output | 1 | Card output enable (low means float) |

## Verification
The assertions assume that the bus never strobes read and write in the same cycle. They also assume that every card and status input is already synchronous to `clk`, so one sampled transition is one event. The bench drives all inputs at the falling clock edge and issues bus strobes only through tasks that raise a single strobe for one cycle. Collisions between an event and a clear are produced on purpose, only by lining up an input toggle with a single read or write strobe.

// File: rtl/sirq_pkg.sv
// Package: shared widths, control bit positions and register selector
// for the socket interrupt block. Assumes an 8-bit register bus.
package sirq_pkg;
    parameter int unsigned REG_W  = 8;
    parameter int unsigned N_EVT  = 4;
    parameter int unsigned N_SRC  = 3;
    localparam int unsigned CTL_USED   = 5;
    localparam int unsigned CTL_PWRDN  = 0;
    localparam int unsigned CTL_CSCLVL = 1;
    localparam int unsigned CTL_W1C    = 2;
    localparam int unsigned CTL_ALVL   = 3;
    localparam int unsigned CTL_BLVL   = 4;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/sirq_ctrl_reg.sv
// Module: global control register shared by both sockets.
// Holds USED writable bits; the upper bits read as zero.
// Assumes the write strobe is already decoded to this register.
module sirq_ctrl_reg #(
    parameter int unsigned REG_W = 8,
    parameter int unsigned USED  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl
);
    localparam int unsigned PAD = REG_W - USED;

    logic [USED-1:0] ctl_q;

    // Capture the writable bits on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (we)
            ctl_q <= wdata[USED-1:0];
    end

    assign ctl = {{PAD{1'b0}}, ctl_q};
endmodule

// File: rtl/sirq_status_flags.sv
// Module: sticky status-change flags, one per input.
// Each input is compared with its previous sample. Any transition sets
// the flag, and a set has priority over a clear in the same cycle.
// Assumes the inputs are synchronous to clk.
module sirq_status_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags,
    output logic [N-1:0] evt
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic prev_q;
        logic flag_q;

        // Track the previous input sample and the sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= ev_in[i];
                flag_q <= 1'b0;
            end else begin
                prev_q <= ev_in[i];
                flag_q <= (flag_q & ~clr[i]) | evt[i];
            end
        end

        assign evt[i]   = ev_in[i] ^ prev_q;
        assign flags[i] = flag_q;
    end
endmodule

// File: rtl/sirq_irq_sig.sv
// Module: host interrupt signaller for one source.
// In level mode the output is the pending condition delayed by one clock.
// In edge mode the output pulses for one clock on each rise of pending.
module sirq_irq_sig (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic pend,
    output logic irq
);
    logic pend_q;

    // Register the previous pending state and the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            pend_q <= pend;
            irq    <= level_mode ? pend : (pend & ~pend_q);
        end
    end
endmodule

// File: rtl/sock_irq_ctl.sv
// Module: socket interrupt control and status, top level.
// Decodes the register bus, holds the shared control byte and the status
// flags, signals three host interrupts and gates the card output enable.
// Assumes bus_rd and bus_wr are never high together.
module sock_irq_ctl
    import sirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             card_a_req,
    input  logic             card_b_req,
    input  logic             cd_in,
    input  logic             rdy_in,
    input  logic             bwarn_in,
    input  logic             bdead_in,
    input  logic             card_access,
    output logic             irq_a,
    output logic             irq_b,
    output logic             irq_csc,
    output logic             card_oe
);
    localparam int unsigned STAT_PAD = REG_W - N_EVT;

    logic [REG_W-1:0] ctl;
    logic [N_EVT-1:0] flags;
    logic [N_EVT-1:0] evt;
    logic [N_EVT-1:0] ev_in;
    logic [N_EVT-1:0] clr;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] mode;
    logic [N_SRC-1:0] irq_v;
    logic             ctl_we;
    logic             stat_rd;
    logic             stat_wr;

    assign ctl_we  = bus_wr && (reg_sel_e'(bus_sel) == SEL_CTRL);
    assign stat_rd = bus_rd && (reg_sel_e'(bus_sel) == SEL_STAT);
    assign stat_wr = bus_wr && (reg_sel_e'(bus_sel) == SEL_STAT);

    sirq_ctrl_reg #(.REG_W(REG_W), .USED(CTL_USED)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (bus_wdata),
        .ctl   (ctl)
    );

    assign ev_in = {bdead_in, bwarn_in, rdy_in, cd_in};

    // Select the clear vector from the active clear method.
    always_comb begin
        clr = '0;
        if (ctl[CTL_W1C]) begin
            if (stat_wr)
                clr = bus_wdata[N_EVT-1:0];
        end else if (stat_rd) begin
            clr = '1;
        end
    end

    sirq_status_flags #(.N(N_EVT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_in (ev_in),
        .clr   (clr),
        .flags (flags),
        .evt   (evt)
    );

    assign pend = {|flags, card_b_req, card_a_req};
    assign mode = {ctl[CTL_CSCLVL], ctl[CTL_BLVL], ctl[CTL_ALVL]};

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        sirq_irq_sig u_sig (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (mode[s]),
            .pend       (pend[s]),
            .irq        (irq_v[s])
        );
    end

    assign irq_a   = irq_v[0];
    assign irq_b   = irq_v[1];
    assign irq_csc = irq_v[2];

    // Return read data one clock after the strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= (reg_sel_e'(bus_sel) == SEL_CTRL) ? ctl
                                                            : {{STAT_PAD{1'b0}}, flags};
        else
            bus_rdata <= '0;
    end

    assign card_oe = !ctl[CTL_PWRDN] || card_access;
endmodule

// File: rtl/sirq_chk.sv
// Module: property checker for sock_irq_ctl, attached with bind.
// Assumes bus strobes are exclusive and all inputs are synchronous.
module sirq_chk
    import sirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [REG_W-1:0] bus_rdata,
    input logic             card_b_req,
    input logic             irq_a,
    input logic             irq_b,
    input logic             irq_csc,
    input logic             card_oe,
    input logic             card_access,
    input logic [REG_W-1:0] ctl,
    input logic [N_EVT-1:0] flags,
    input logic [N_EVT-1:0] evt
);
    // Input rule: one strobe at a time (R2, R7).
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel) |=> (bus_rdata[REG_W-1:CTL_USED] == '0));

    assert_edge_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl[CTL_ALVL] && irq_a) |=> !irq_a);

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[CTL_BLVL] |=> (irq_b == $past(card_b_req)));

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel && !ctl[CTL_W1C]) |=> (flags == $past(evt)));

    assert_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel && ctl[CTL_W1C]) |=> (flags == ($past(flags) | $past(evt))));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    assert_csc_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[CTL_CSCLVL] |=> (irq_csc == $past(|flags)));

    assert_oe_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[CTL_PWRDN] |-> card_oe);

    assert_oe_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CTL_PWRDN] && !card_access) |-> !card_oe);
endmodule

bind sock_irq_ctl sirq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .card_b_req  (card_b_req),
    .irq_a       (irq_a),
    .irq_b       (irq_b),
    .irq_csc     (irq_csc),
    .card_oe     (card_oe),
    .card_access (card_access),
    .ctl         (ctl),
    .flags       (flags),
    .evt         (evt)
);

// File: tb/sim_sock_irq_ctl.sv
// Bench: scoreboard for sock_irq_ctl. The read task queues expected data
// and a monitor compares bus_rdata on the falling edge after each read.
// Interrupt and enable pins are checked directly on falling edges.
module sim_sock_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       card_a_req = 1'b0;
    logic       card_b_req = 1'b0;
    logic       cd_in = 1'b0;
    logic       rdy_in = 1'b0;
    logic       bwarn_in = 1'b0;
    logic       bdead_in = 1'b0;
    logic       card_access = 1'b0;
    logic       irq_a;
    logic       irq_b;
    logic       irq_csc;
    logic       card_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    sock_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_a_req(card_a_req), .card_b_req(card_b_req), .cd_in(cd_in),
        .rdy_in(rdy_in), .bwarn_in(bwarn_in), .bdead_in(bdead_in),
        .card_access(card_access), .irq_a(irq_a), .irq_b(irq_b),
        .irq_csc(irq_csc), .card_oe(card_oe)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note read strobes and compare returned data.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underrun", 8'h01, 8'h00);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic sel, logic [7:0] exp, string tag);
        sb_q.push_back('{tag, exp});
        bus_sel = sel; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 irq_a", {7'd0, irq_a}, 8'h00);
        check("R1 irq_b", {7'd0, irq_b}, 8'h00);
        check("R1 irq_csc", {7'd0, irq_csc}, 8'h00);
        check("R1 card_oe", {7'd0, card_oe}, 8'h01);
        rd(1'b0, 8'h00, "R1 ctl reset");
        rd(1'b1, 8'h00, "R1 status reset");

        // R2: reserved bits and read-back
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h1F, "R2 reserved bits zero");
        wr(1'b0, 8'hEA);
        rd(1'b0, 8'h0A, "R2 read-back");
        wr(1'b0, 8'h00);

        // R3: card A edge then level
        card_a_req = 1'b1;
        step(1); check("R3 edge pulse", {7'd0, irq_a}, 8'h01);
        step(1); check("R3 edge single", {7'd0, irq_a}, 8'h00);
        card_a_req = 1'b0; step(1);
        wr(1'b0, 8'h08);
        card_a_req = 1'b1;
        step(1); check("R3 level high", {7'd0, irq_a}, 8'h01);
        step(2); check("R3 level held", {7'd0, irq_a}, 8'h01);
        check("R4 B untouched by A", {7'd0, irq_b}, 8'h00);
        card_a_req = 1'b0;
        step(1); check("R3 level drop", {7'd0, irq_a}, 8'h00);

        // R4: card B edge then level
        wr(1'b0, 8'h00);
        card_b_req = 1'b1;
        step(1); check("R4 edge pulse", {7'd0, irq_b}, 8'h01);
        step(1); check("R4 edge single", {7'd0, irq_b}, 8'h00);
        card_b_req = 1'b0; step(1);
        wr(1'b0, 8'h10);
        card_b_req = 1'b1;
        step(3); check("R4 level held", {7'd0, irq_b}, 8'h01);
        card_b_req = 1'b0;
        step(1); check("R4 level drop", {7'd0, irq_b}, 8'h00);
        wr(1'b0, 8'h00);

        // R5 and R6: flag bits and clear on read
        cd_in = 1'b1; step(1);
        rd(1'b1, 8'h01, "R5 card detect flag");
        rd(1'b1, 8'h00, "R6 cleared by read");
        rdy_in = 1'b1; step(1);
        rd(1'b1, 8'h02, "R5 ready rise");
        rdy_in = 1'b0; step(1);
        rd(1'b1, 8'h02, "R5 ready fall");
        bwarn_in = 1'b1; bdead_in = 1'b1; step(1);
        rd(1'b1, 8'h0C, "R5 battery flags");

        // R7: status write ignored in clear-on-read mode
        cd_in = 1'b0; step(1);
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'h01, "R7 write ignored in read-clear mode");

        // R7: write-1-to-clear mode
        wr(1'b0, 8'h04);
        cd_in = 1'b1; rdy_in = 1'b1; step(1);
        rd(1'b1, 8'h03, "R7 w1c first read");
        rd(1'b1, 8'h03, "R7 read leaves flags");
        wr(1'b1, 8'h01);
        rd(1'b1, 8'h02, "R7 clear selected bit");
        wr(1'b1, 8'h02);
        rd(1'b1, 8'h00, "R7 clear remaining bit");

        // R8: event wins over write clear
        cd_in = 1'b0; step(1);
        cd_in = 1'b1;
        wr(1'b1, 8'h01);
        rd(1'b1, 8'h01, "R8 event kept over write clear");
        wr(1'b1, 8'h01);

        // R8: event wins over read clear
        wr(1'b0, 8'h00);
        cd_in = 1'b0;
        rd(1'b1, 8'h00, "R8 read returns prior flags");
        rd(1'b1, 8'h01, "R8 event kept over read clear");

        // R9: status change interrupt, edge mode
        bwarn_in = 1'b0;
        step(2); check("R9 edge pulse", {7'd0, irq_csc}, 8'h01);
        step(1); check("R9 edge single", {7'd0, irq_csc}, 8'h00);
        rd(1'b1, 8'h04, "R9 warn flag");

        // R9: level mode
        wr(1'b0, 8'h02);
        rdy_in = 1'b0;
        step(2); check("R9 level high", {7'd0, irq_csc}, 8'h01);
        step(2); check("R9 level held", {7'd0, irq_csc}, 8'h01);
        rd(1'b1, 8'h02, "R9 ready flag");
        check("R9 level before clear seen", {7'd0, irq_csc}, 8'h01);
        step(1); check("R9 level drop", {7'd0, irq_csc}, 8'h00);

        // R10: power-down gating
        wr(1'b0, 8'h01);
        check("R10 floated", {7'd0, card_oe}, 8'h00);
        card_access = 1'b1; #1;
        check("R10 access wakes", {7'd0, card_oe}, 8'h01);
        card_access = 1'b0; #1;
        check("R10 float after access", {7'd0, card_oe}, 8'h00);
        step(1);
        bdead_in = 1'b0; step(1);
        rd(1'b1, 8'h08, "R10 flag captured in power-down");
        card_a_req = 1'b1;
        step(1); check("R10 irq in power-down", {7'd0, irq_a}, 8'h01);
        card_a_req = 1'b0;
        wr(1'b0, 8'h00);
        check("R10 awake", {7'd0, card_oe}, 8'h01);

        step(3);
        check("scoreboard drained", 8'(sb_q.size()), 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule